// File: doc/BRIEF.md
# Overlapping 1011 Serial Pattern Detector

This block watches a single serial data line, taking one bit on every rising clock edge, and raises a one-bit flag when the most recent four bits form the pattern 1011. It is a Mealy machine: the flag depends on the stored progress and on the bit now present. The flag therefore goes high in the same cycle that the closing 1 of the pattern is on the input, with no extra register stage.

Two stored bits record how much of the pattern has been seen so far. The codes are 00 for no progress, 01 for a trailing "1", 10 for a trailing "10" and 11 for a trailing "101". When a bit breaks the pattern, the machine falls back to the longest suffix of the stream that is still a valid prefix of the pattern. Detections can therefore overlap: the last 1 of one match can also be the first 1 of the next. An active-low asynchronous reset clears the progress to 00.

Top module: `seq_det_1011`

## Requirements
- R1: While rst_ni is low, and in the cycle after it is released, the progress is 00. A 1 on bit_i in that first cycle does not raise det_o.
- R2: det_o is 1 exactly when the three bits accepted before the current cycle, followed by the present bit_i, read 1,0,1,1 in arrival order. It is 0 in every other case.
- R3: Detections overlap. The stream 1011011 raises det_o on its 4th and on its 7th bit only, and the state after any detection is 01.
- R4: det_o responds in the same cycle to a change of bit_i, before the next clock edge.
- R5: A 0 that arrives while the progress is "10" clears the progress to 00. The stream 1001011 raises det_o only on its 7th bit.
- R6: A 0 that arrives while the progress is "101" leaves the progress at "10". The stream 101011 raises det_o only on its 6th bit.
- R7: Repeated 1s keep the progress at "1". The stream 1111011 raises det_o only on its 7th bit.
- R8: A reset applied part-way through a pattern discards the progress made so far. After 101, a reset, and then a 1, det_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial data bit, taken at each rising edge |
| det_o | output | 1 | High while the current bit completes 1011 |

## Verification
The two state bits are hidden, so a wrong transition shows only through det_o. A bad fall-back shows up as a missed or extra detection. This appears at the earliest when the next 1 arrives after the faulty step, and at the latest three bits later, when a full pattern should or should not complete. The bench therefore drives streams that pass through every fall-back edge and then end in a pattern, and it compares det_o on every cycle. Because the output is Mealy, it also checks det_o before the clock edge that takes the closing bit.

// File: rtl/seq_det_pkg.sv
package seq_det_pkg;
  localparam int unsigned StW = 2;

  typedef enum logic [StW-1:0] {
    ST_NONE = 2'b00,
    ST_1    = 2'b01,
    ST_10   = 2'b10,
    ST_101  = 2'b11
  } prog_e;
endpackage

// File: rtl/seq_det_next.sv
module seq_det_next
  import seq_det_pkg::*;
(
  input  prog_e cur_i,
  input  logic  bit_i,
  output prog_e nxt_o
);
  always_comb begin
    unique case (cur_i)
      ST_NONE: nxt_o = bit_i ? ST_1   : ST_NONE;
      ST_1:    nxt_o = bit_i ? ST_1   : ST_10;
      ST_10:   nxt_o = bit_i ? ST_101 : ST_NONE;
      ST_101:  nxt_o = bit_i ? ST_1   : ST_10;  // overlap fall-back
      default: nxt_o = ST_NONE;
    endcase
  end
endmodule

// File: rtl/seq_det_out.sv
module seq_det_out
  import seq_det_pkg::*;
(
  input  prog_e cur_i,
  input  logic  bit_i,
  output logic  hit_o
);
  always_comb hit_o = (cur_i == ST_101) & bit_i;
endmodule

// File: rtl/seq_det_1011.sv
module seq_det_1011
  import seq_det_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic det_o
);
  prog_e state_q, state_d;

  seq_det_next u_next (.cur_i(state_q), .bit_i(bit_i), .nxt_o(state_d));
  seq_det_out  u_out  (.cur_i(state_q), .bit_i(bit_i), .hit_o(det_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_NONE;
    else         state_q <= state_d;
  end

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (state_q == ST_NONE && !det_o));

  assert_after_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o |=> (state_q == ST_1));

  assert_zero_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_10 && !bit_i) |=> (state_q == ST_NONE && !det_o));

  assert_fallback_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_101 && !bit_i) |=> (state_q == ST_10));

  assert_ones_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_1 && bit_i) |=> (state_q == ST_1 && !det_o));
endmodule

// File: tb/seq_det_1011_tb_top.sv
module seq_det_1011_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_i = 1'b0;
  logic det_o;

  int total = 0;
  int bad = 0;
  bit hist[$];   // bits accepted since reset
  bit done = 1'b0;

  seq_det_1011 dut_i (.clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .det_o(det_o));

  always #10 clk_i = ~clk_i;

  function automatic bit model_hit(bit b);
    int n = hist.size();
    if (n < 3) return 1'b0;
    return hist[n-3] && !hist[n-2] && hist[n-1] && b;
  endfunction

  task automatic check(string req, bit act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // drive a bit after the falling edge, check before the rising edge
  task automatic feed(bit b, string req);
    @(negedge clk_i);
    bit_i = b;
    #5;
    check(req, det_o, model_hit(b));
    @(posedge clk_i);
    hist.push_back(b);
  endtask

  task automatic feed_str(string s, string req);
    for (int i = 0; i < s.len(); i++) feed(s[i] == "1", req);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    bit_i = 1'b1;
    #3;
    check("R1", det_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    hist.delete();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk_i);
    check("R1", det_o, 1'b0);
    do_reset();
    feed(1'b1, "R1");                // first bit 1 after reset: no hit
    do_reset();
    feed_str("1011011", "R3");       // hits on 4th and 7th
    do_reset();
    feed_str("1001011", "R5");
    do_reset();
    feed_str("101011", "R6");
    do_reset();
    feed_str("1111011", "R7");
    // R4: output follows bit_i within a cycle while in "101"
    do_reset();
    feed_str("101", "R4");
    @(negedge clk_i);
    bit_i = 1'b0; #2; check("R4", det_o, 1'b0);
    bit_i = 1'b1; #2; check("R4", det_o, 1'b1);
    bit_i = 1'b0; #2; check("R4", det_o, 1'b0);
    @(posedge clk_i);
    hist.push_back(1'b0);
    feed(1'b1, "R4");
    // R8: async reset mid-pattern
    do_reset();
    feed_str("101", "R8");
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    rst_ni = 1'b1;
    hist.delete();
    bit_i = 1'b1;
    #2;
    check("R8", det_o, 1'b0);
    @(posedge clk_i);
    hist.push_back(1'b1);
    feed_str("011", "R8");
    // R2: longer mixed streams compared every cycle
    do_reset();
    feed_str("0010110101101110110010111011", "R2");
    for (int i = 0; i < 300; i++) feed(((i * 7 + (i >> 2)) % 3) != 0, "R2");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule